// File: doc/BRIEF.md
# Serial Bit-Clock Divider

This block produces the timing for a synchronous serial port. It divides the peripheral clock in two cascaded stages. A prescaler counts off an even number of cycles. A rate stage counts a number of prescaler terminal counts. The result is a one-cycle bit tick, repeating every divisor × (1 + rate) clock cycles.

A second strobe pulses twice per bit period: once half-way through the period and once together with the bit tick. A shift engine can toggle its serial clock line on each strobe, so the line makes one full cycle per bit. Both settings sit in registers that are written through a small write port. The port has a select bit that chooses between the prescale divisor and the rate value. Both registers can be read back. A parameter chooses whether the two strobes are decoded directly from the counters or taken from a flop one cycle later.

Top module: `sclk_divider`

## Requirements
- R1: After reset both registers read 0, and neither strobe is asserted.
- R2: A write with select 0 loads the prescale register. Bit 0 of that register always reads 0, so an odd value reads back one lower.
- R3: A write with select 1 loads the rate register. All 8 bits read back unchanged.
- R4: A stored prescale value of 0 divides by 2, so the counters never stall.
- R5: With divisor D (even, 2 to 254) and rate value N (0 to 255), the bit tick is a one-cycle pulse that repeats every D × (N + 1) cycles.
- R6: While the enable is low, both counter stages hold at zero and no strobe is emitted. After the enable rises, the first bit tick arrives on the D × (N + 1)-th enabled cycle.
- R7: The half strobe pulses exactly twice per bit period. One pulse comes (D/2) × (N + 1) cycles after the period starts, and the other comes in the same cycle as the bit tick.
- R8: If a register write lowers the terminal count below a counter's present value while the block runs, the counter ends at its next step. It does not run on past the old limit. After that, the new period applies.
- R9: With the registered-output option, both strobes appear exactly one cycle later than with the direct option, and they are otherwise identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Port enable; low holds both counters at zero |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 prescale divisor, 1 rate value |
| cfg_wdata | input | 8 | Write data |
| psc_rd | output | 8 | Prescale register readback (bit 0 always 0) |
| rate_rd | output | 8 | Rate register readback |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| half_tick | output | 1 | Serial clock toggle strobe, twice per bit period |

## Verification
The bench builds two copies with 8-bit divisor and rate widths. One copy uses direct strobe decode and the other uses the registered-output option. Both copies are compared on every cycle against one behavioural model, and the registered copy is compared against the model output delayed by one cycle. The 8-bit widths bring the extreme settings within reach: the stored zero divisor, the largest divisor of 254, rate 0, and both odd and even values of rate + 1, which place the mid-period strobe in different prescaler phases. The bench also lowers the rate while the counters run, to exercise the case where a counter is already past its new limit.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

   // Register select encoding on the write port.
   localparam logic SEL_PSC  = 1'b0;
   localparam logic SEL_RATE = 1'b1;

   // Pair of strobes produced by the rate stage.
   typedef struct packed {
      logic bit_tick;
      logic half_tick;
   } strobe_t;

   // Smallest divisor the prescaler ever applies.
   localparam int unsigned MIN_DIV = 2;

endpackage

// File: rtl/sclk_cfg_regs.sv
module sclk_cfg_regs
   import sclk_div_pkg::*;
#(
   parameter int unsigned PSC_W  = 8,
   parameter int unsigned RATE_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [PSC_W-1:0]  psc_q,
   output logic [RATE_W-1:0] rate_q
);

   // Only the upper bits of the divisor are stored; bit 0 is a constant zero.
   logic [PSC_W-1:1] psc_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         psc_hi <= '0;
      end else if (wr_en && (wr_sel == SEL_PSC)) begin
         psc_hi <= wr_data[PSC_W-1:1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= '0;
      end else if (wr_en && (wr_sel == SEL_RATE)) begin
         rate_q <= wr_data[RATE_W-1:0];
      end
   end

   assign psc_q = {psc_hi, 1'b0};

endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
   import sclk_div_pkg::*;
#(
   parameter int unsigned PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PSC_W-1:0] psc_q,
   output logic             pre_tc,
   output logic             pre_mid
);

   localparam logic [PSC_W-1:0] DIV_FLOOR = PSC_W'(MIN_DIV);

   logic [PSC_W-1:0] pcnt;
   logic [PSC_W-1:0] div_eff;
   logic [PSC_W-1:0] last_cnt;
   logic [PSC_W-1:0] mid_cnt;

   // A stored zero would stall the count; fall back to the smallest divisor.
   assign div_eff  = (psc_q == '0) ? DIV_FLOOR : psc_q;
   assign last_cnt = div_eff - PSC_W'(1);
   assign mid_cnt  = (div_eff >> 1) - PSC_W'(1);

   // Terminal on "at or past" so a shrunken divisor ends the count at once.
   assign pre_tc  = en && (pcnt >= last_cnt);
   assign pre_mid = en && (pcnt == mid_cnt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (!en || pre_tc) begin
         pcnt <= '0;
      end else begin
         pcnt <= pcnt + PSC_W'(1);
      end
   end

endmodule

// File: rtl/sclk_rate_stage.sv
module sclk_rate_stage
   import sclk_div_pkg::*;
#(
   parameter int unsigned RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              pre_tc,
   input  logic              pre_mid,
   input  logic [RATE_W-1:0] rate_q,
   output strobe_t           strobe
);

   logic [RATE_W-1:0] scnt;
   logic              at_end;
   logic              mid_slot;
   logic              mid_hit;

   assign at_end = (scnt >= rate_q);

   // Mid-period point: with rate+1 odd the half falls inside a prescaler
   // period, with rate+1 even it falls on a prescaler terminal count.
   assign mid_slot = (scnt == (rate_q >> 1));
   assign mid_hit  = mid_slot && (rate_q[0] ? pre_tc : pre_mid);

   assign strobe.bit_tick  = pre_tc && at_end;
   assign strobe.half_tick = (pre_tc && at_end) || (en && mid_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scnt <= '0;
      end else if (!en) begin
         scnt <= '0;
      end else if (pre_tc) begin
         scnt <= at_end ? '0 : (scnt + RATE_W'(1));
      end
   end

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
   import sclk_div_pkg::*;
#(
   parameter int unsigned PSC_W    = 8,
   parameter int unsigned RATE_W   = 8,
   parameter int unsigned TICK_REG = 0,
   localparam int unsigned DATA_W  = (PSC_W > RATE_W) ? PSC_W : RATE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [PSC_W-1:0]  psc_rd,
   output logic [RATE_W-1:0] rate_rd,
   output logic              bit_tick,
   output logic              half_tick
);

   generate
      if (PSC_W < 2) begin : g_bad_psc_w
         $error("PSC_W must be at least 2");
      end
      if (RATE_W < 1) begin : g_bad_rate_w
         $error("RATE_W must be at least 1");
      end
      if (TICK_REG > 1) begin : g_bad_tick_reg
         $error("TICK_REG must be 0 or 1");
      end
   endgenerate

   logic    pre_tc;
   logic    pre_mid;
   strobe_t strobe;
   logic    tick_raw;
   logic    half_raw;

   sclk_cfg_regs #(
      .PSC_W  (PSC_W),
      .RATE_W (RATE_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_wdata),
      .psc_q   (psc_rd),
      .rate_q  (rate_rd)
   );

   sclk_prescaler #(
      .PSC_W (PSC_W)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .psc_q   (psc_rd),
      .pre_tc  (pre_tc),
      .pre_mid (pre_mid)
   );

   sclk_rate_stage #(
      .RATE_W (RATE_W)
   ) u_rate (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .pre_tc  (pre_tc),
      .pre_mid (pre_mid),
      .rate_q  (rate_rd),
      .strobe  (strobe)
   );

   assign tick_raw = strobe.bit_tick;
   assign half_raw = strobe.half_tick;

   generate
      if (TICK_REG == 1) begin : g_out_reg
         strobe_t strobe_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               strobe_q <= '0;
            end else begin
               strobe_q <= strobe;
            end
         end
         assign bit_tick  = strobe_q.bit_tick;
         assign half_tick = strobe_q.half_tick;
      end else begin : g_out_comb
         assign bit_tick  = strobe.bit_tick;
         assign half_tick = strobe.half_tick;
      end
   endgenerate

endmodule

// File: rtl/sclk_divider_chk.sv
module sclk_divider_chk #(
   parameter int unsigned PSC_W    = 8,
   parameter int unsigned TICK_REG = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [PSC_W-1:0] psc_rd,
   input logic             tick_raw,
   input logic             half_raw,
   input logic             bit_tick,
   input logic             half_tick
);

   // R2: the divisor register never holds an odd value.
   p_psc_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
      psc_rd[0] == 1'b0);

   // R6: no strobe while the port is disabled.
   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!tick_raw && !half_raw));

   // R5: the bit tick never lasts more than one cycle.
   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick_raw |=> !tick_raw);

   // R7: every bit tick is also a serial clock toggle.
   p_tick_in_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick_raw |-> half_raw);

   generate
      if (TICK_REG == 1) begin : g_reg_chk
         // R9: registered strobes trail the decoded ones by one cycle.
         p_delay_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
            bit_tick == $past(tick_raw));
         p_delay_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
            half_tick == $past(half_raw));
      end
   endgenerate

endmodule

bind sclk_divider sclk_divider_chk #(
   .PSC_W    (PSC_W),
   .TICK_REG (TICK_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .psc_rd    (psc_rd),
   .tick_raw  (tick_raw),
   .half_raw  (half_raw),
   .bit_tick  (bit_tick),
   .half_tick (half_tick)
);

// File: tb/test_sclk_divider.sv
`timescale 1ns/1ps
module test_sclk_divider;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       cfg_we = 1'b0;
   logic       cfg_sel = 1'b0;
   logic [7:0] cfg_wdata = '0;

   logic [7:0] psc_rd, rate_rd, psc_rd_q, rate_rd_q;
   logic       bit_tick, half_tick, bit_tick_q, half_tick_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   sclk_divider #(.PSC_W(8), .RATE_W(8), .TICK_REG(0)) i_sclk_divider (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .psc_rd(psc_rd), .rate_rd(rate_rd),
      .bit_tick(bit_tick), .half_tick(half_tick));

   sclk_divider #(.PSC_W(8), .RATE_W(8), .TICK_REG(1)) i_sclk_divider_q (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .psc_rd(psc_rd_q), .rate_rd(rate_rd_q),
      .bit_tick(bit_tick_q), .half_tick(half_tick_q));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_psc = 0, m_rate = 0, m_pc = 0, m_sc = 0;
   bit exp_bit_prev = 1'b0, exp_half_prev = 1'b0;

   function automatic int eff_div(input int p);
      return (p == 0) ? 2 : p;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_psc = 0; m_rate = 0; m_pc = 0; m_sc = 0;
      end else begin
         int d;
         d = eff_div(m_psc);
         if (!en) begin
            m_pc = 0; m_sc = 0;
         end else if (m_pc >= d - 1) begin
            m_pc = 0;
            m_sc = (m_sc >= m_rate) ? 0 : m_sc + 1;
         end else begin
            m_pc = m_pc + 1;
         end
         if (cfg_we) begin
            if (cfg_sel == 1'b0) m_psc = int'(cfg_wdata) & 'hFE;
            else                 m_rate = int'(cfg_wdata);
         end
      end
   end

   // Per-cycle comparison, away from the active edge.
   always @(negedge clk) begin
      if (!done) begin
         int d;
         bit eb, eh, endp;
         d = eff_div(m_psc);
         endp = en && (m_pc >= d - 1);
         eb = endp && (m_sc >= m_rate);
         eh = eb || (en && (m_sc == m_rate / 2) &&
                     (((m_rate % 2) == 1) ? endp : (m_pc == d / 2 - 1)));
         // R5: bit tick timing; R6: quiet when disabled
         check(bit_tick == eb, "R5", "bit_tick", int'(bit_tick), int'(eb));
         // R7: toggle strobe timing
         check(half_tick == eh, "R7", "half_tick", int'(half_tick), int'(eh));
         // R9: registered variant trails by one cycle
         check(bit_tick_q == exp_bit_prev, "R9", "bit_tick_q",
               int'(bit_tick_q), int'(exp_bit_prev));
         check(half_tick_q == exp_half_prev, "R9", "half_tick_q",
               int'(half_tick_q), int'(exp_half_prev));
         // R2 / R3 readback against the model registers
         check(int'(psc_rd) == m_psc, "R2", "psc_rd", int'(psc_rd), m_psc);
         check(int'(rate_rd) == m_rate, "R3", "rate_rd", int'(rate_rd), m_rate);
         exp_bit_prev  = rst_n ? eb : 1'b0;
         exp_half_prev = rst_n ? eh : 1'b0;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic write_reg(input logic sel, input logic [7:0] val);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      step();
      cfg_we = 1'b0; cfg_wdata = '0;
   endtask

   // Measures one full bit period and the toggle strobes inside it.
   task automatic measure(input int exp_p, input string req);
      int n = 0;
      int halves = 0;
      int guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!bit_tick && guard < 70000);
      do begin
         @(negedge clk);
         n++;
         if (half_tick) halves++;
      end while (!bit_tick && n < 70000);
      check(n == exp_p, req, "bit period", n, exp_p);
      check(halves == 2, "R7", "toggles per period", halves, 2);
   endtask

   // ---------------- main sequence ----------------
   initial begin
      step(); step(); step();
      @(negedge clk);
      // R1: reset state
      check(psc_rd == 8'd0, "R1", "psc after reset", int'(psc_rd), 0);
      check(rate_rd == 8'd0, "R1", "rate after reset", int'(rate_rd), 0);
      check(!bit_tick && !half_tick, "R1", "strobes in reset",
            int'({bit_tick, half_tick}), 0);
      step();
      rst_n = 1'b1;
      step();

      // R2: odd write reads back with bit 0 cleared
      write_reg(1'b0, 8'd7);
      @(negedge clk);
      check(psc_rd == 8'd6, "R2", "odd divisor readback", int'(psc_rd), 6);
      // R3: rate write readback
      write_reg(1'b1, 8'd4);
      @(negedge clk);
      check(rate_rd == 8'd4, "R3", "rate readback", int'(rate_rd), 4);

      // R5: D=6, N=4 -> 30 cycles (rate+1 odd)
      step(); en = 1'b1;
      measure(30, "R5");
      // R5: D=4, N=5 -> 24 (rate+1 even)
      write_reg(1'b0, 8'd4); write_reg(1'b1, 8'd5);
      measure(24, "R5"); measure(24, "R5");
      // R5: smallest divisor, rate 0 -> 2
      write_reg(1'b0, 8'd2); write_reg(1'b1, 8'd0);
      measure(2, "R5"); measure(2, "R5");
      // R4: stored zero acts as 2
      write_reg(1'b0, 8'd0); write_reg(1'b1, 8'd3);
      measure(8, "R4"); measure(8, "R4");
      // R5: largest divisor
      write_reg(1'b0, 8'd254); write_reg(1'b1, 8'd1);
      measure(508, "R5");

      // R6: disabled -> nothing, then a full period after enable
      write_reg(1'b0, 8'd10); write_reg(1'b1, 8'd2);
      en = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         check(!bit_tick && !half_tick, "R6", "strobe while disabled",
               int'({bit_tick, half_tick}), 0);
      end
      step();
      en = 1'b1;
      begin
         int n = 0;
         do begin
            @(negedge clk);
            n++;
         end while (!bit_tick && n < 1000);
         check(n == 30, "R6", "first tick after enable", n, 30);
      end

      // R8: lower the rate while the second stage is well advanced
      write_reg(1'b0, 8'd16); write_reg(1'b1, 8'd9);
      measure(160, "R8");
      for (int i = 0; i < 100; i++) step();
      write_reg(1'b1, 8'd2);
      begin
         int n = 0;
         do begin
            @(negedge clk);
            n++;
         end while (!bit_tick && n < 1000);
         check(n <= 17, "R8", "cycles to early terminal", n, 17);
      end
      measure(48, "R8");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule